// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning and Reset Request

This block is a memory-mapped watchdog. A single up-counter advances once per clock while counting is turned on and is compared against two programmable limits. The lower limit, the warning threshold, raises a level interrupt so that software gets a last chance to react. The upper limit, the reset threshold, drives a reset request toward the system reset controller. Software keeps the timer from firing by writing the restart register, which returns the count to zero and withdraws both outputs.

A sticky cause flag records that the reset request fired. It is cleared only by power-on reset or by software writing 1 to it. The ordinary system reset, the one this block requests, returns every other register to its default value but leaves that flag set. After a restart, software can read the flag to learn why the system came back up.

Top module: `wdog_bark_bite`

## Requirements
- R1: Byte offsets: restart register 0x04, control 0x08, cause 0x0C, warning threshold 0x10, reset threshold 0x14. A read strobe loads `rdata` on that clock edge. Control reads back bit 0 = count enable and bit 1 = interrupt enable. Cause reads back its flag in bit 0. The thresholds read back as written, zero-extended. The restart register reads 0.
- R2: While control bit 0 is clear, the count stays at zero and neither `bark_irq` nor `bite_req` is asserted.
- R3: With reset threshold B, `bite_req` goes high on the (B+1)-th rising edge after the edge that samples the enabling control write, and is low before that edge.
- R4: With interrupt enable set and warning threshold A below B, `bark_irq` goes high on the (A+1)-th edge after the enabling write. It then stays high until a restart or a disable.
- R5: With control bit 1 clear, `bark_irq` stays low while the reset request still fires.
- R6: When A is greater than or equal to B, `bark_irq` is never raised, and `bite_req` follows R3.
- R7: A write to the restart register with bit 0 = 1 clears both outputs on that edge and restarts the count from zero. A write with bit 0 = 0 has no effect.
- R8: A control write with bit 0 = 0 clears both outputs on the edge that samples it.
- R9: The count saturates at B and never wraps. `bite_req` stays high for as long as counting stays on, including when B is the largest value the counter can hold.
- R10: The cause flag is set on the edge after one where `bite_req` is high. It survives `rst_sys`. It is cleared by writing 1 to cause bit 0 or by `rst_por`. Writing 0 to cause bit 0 has no effect.
- R11: `rst_sys` and `rst_por` clear the control register and set both thresholds to all ones.
- R12: The sequence disable, restart, reload both thresholds, enable makes the new thresholds govern the next count period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each counter tick is one cycle |
| rst_por | input | 1 | Synchronous active-high power-on reset; clears everything |
| rst_sys | input | 1 | Synchronous active-high system reset; keeps the cause flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bark_irq | output | 1 | Early-warning interrupt, level high |
| bite_req | output | 1 | Reset request to the system reset controller |
| wdog_caused | output | 1 | Sticky flag: the reset request has fired |

## Verification
The bench builds the block with a 12-bit counter and the default 5-bit address. The narrower counter puts the all-ones default threshold only 4096 ticks away. That makes the saturation case at the counter's full range (R9) and the values restored after reset (R11) reachable in a short run. The small thresholds the bench writes (single digits) let each edge-exact timing check for the warning, the reset request and the restart fit inside a few cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W   = 32;
  // byte offsets decoded by the register port
  localparam int unsigned OFS_KICK = 'h04;
  localparam int unsigned OFS_CTRL = 'h08;
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_BARK = 'h10;
  localparam int unsigned OFS_BITE = 'h14;
  // control field positions
  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_IRQ = 1;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 28
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bite_seen,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              irq_en,
  output logic [CNT_W-1:0]  bark_thr,
  output logic [CNT_W-1:0]  bite_thr,
  output logic              kick,
  output logic              stop,
  output logic              caused
);
  localparam logic [CNT_W-1:0] THR_RST = {CNT_W{1'b1}};

  logic rst_any;
  logic sel_kick, sel_ctrl, sel_stat, sel_bark, sel_bite;
  logic [DATA_W-CNT_W-1:0] unused_hi;

  assign rst_any  = rst_por | rst_sys;
  assign sel_kick = (addr == ADDR_W'(OFS_KICK));
  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_bark = (addr == ADDR_W'(OFS_BARK));
  assign sel_bite = (addr == ADDR_W'(OFS_BITE));
  assign unused_hi = wdata[DATA_W-1:CNT_W];

  // one-edge command pulses toward the counter
  assign kick = wr_en & sel_kick & wdata[0];
  assign stop = wr_en & sel_ctrl & ~wdata[CTRL_RUN];

  always_ff @(posedge clk) begin
    if (rst_any) begin
      run      <= 1'b0;
      irq_en   <= 1'b0;
      bark_thr <= THR_RST;
      bite_thr <= THR_RST;
    end else if (wr_en) begin
      if (sel_ctrl) begin
        run    <= wdata[CTRL_RUN];
        irq_en <= wdata[CTRL_IRQ];
      end
      if (sel_bark) bark_thr <= wdata[CNT_W-1:0];
      if (sel_bite) bite_thr <= wdata[CNT_W-1:0];
    end
  end

  // cause flag lives in the power-on domain only
  always_ff @(posedge clk) begin
    if (rst_por)                             caused <= 1'b0;
    else if (bite_seen)                      caused <= 1'b1;
    else if (wr_en && sel_stat && wdata[0])  caused <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (sel_ctrl) begin
        rdata[CTRL_RUN] <= run;
        rdata[CTRL_IRQ] <= irq_en;
      end
      if (sel_stat) rdata[0] <= caused;
      if (sel_bark) rdata <= DATA_W'(bark_thr);
      if (sel_bite) rdata <= DATA_W'(bite_thr);
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             irq_en,
  input  logic             kick,
  input  logic             stop,
  input  logic [CNT_W-1:0] bark_thr,
  input  logic [CNT_W-1:0] bite_thr,
  output logic             bark_irq,
  output logic             bite_req
);
  logic [CNT_W-1:0] cnt_q;
  logic clr, at_bite, at_bark, bark_ok;

  assign clr     = kick | stop | ~run;
  assign at_bite = (cnt_q >= bite_thr);
  assign at_bark = (cnt_q >= bark_thr);
  assign bark_ok = (bark_thr < bite_thr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      bark_irq <= 1'b0;
      bite_req <= 1'b0;
    end else begin
      if (!at_bite) cnt_q <= cnt_q + 1'b1;
      bite_req <= at_bite;
      if (irq_en && at_bark && bark_ok) bark_irq <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 28
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              bark_irq,
  output logic              bite_req,
  output logic              wdog_caused
);
  logic             run_w, irq_en_w, kick_w, stop_w;
  logic [CNT_W-1:0] bark_thr_w, bite_thr_w;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .bite_seen(bite_req), .rdata(rdata),
    .run(run_w), .irq_en(irq_en_w),
    .bark_thr(bark_thr_w), .bite_thr(bite_thr_w),
    .kick(kick_w), .stop(stop_w), .caused(wdog_caused)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst_por | rst_sys),
    .run(run_w), .irq_en(irq_en_w), .kick(kick_w), .stop(stop_w),
    .bark_thr(bark_thr_w), .bite_thr(bite_thr_w),
    .bark_irq(bark_irq), .bite_req(bite_req)
  );
endmodule

// File: rtl/wdog_bark_bite_chk.sv
module wdog_bark_bite_chk
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 28
) (
  input logic              clk,
  input logic              rst_por,
  input logic              rst_sys,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              bark_irq,
  input logic              bite_req,
  input logic              wdog_caused,
  input logic              irq_en,
  input logic [CNT_W-1:0]  bark_thr,
  input logic [CNT_W-1:0]  bite_thr
);
  logic kick_wr, stop_wr, clr_wr;
  assign kick_wr = wr_en && (addr == ADDR_W'(OFS_KICK)) && wdata[0];
  assign stop_wr = wr_en && (addr == ADDR_W'(OFS_CTRL)) && !wdata[0];
  assign clr_wr  = wr_en && (addr == ADDR_W'(OFS_STAT)) && wdata[0];

  assert_kick_clears_R7: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    kick_wr |=> (!bite_req && !bark_irq));

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    stop_wr |=> (!bite_req && !bark_irq));

  assert_bark_needs_irq_en_R5: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    $rose(bark_irq) |-> $past(irq_en));

  assert_bark_below_bite_R6: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    $rose(bark_irq) |-> $past(bark_thr < bite_thr));

  assert_flag_follows_bite_R10: assert property (@(posedge clk) disable iff (rst_por)
    bite_req |=> wdog_caused);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst_por)
    (wdog_caused && !clr_wr) |=> wdog_caused);
endmodule

bind wdog_bark_bite wdog_bark_bite_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
  .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .bark_irq(bark_irq), .bite_req(bite_req), .wdog_caused(wdog_caused),
  .irq_en(irq_en_w), .bark_thr(bark_thr_w), .bite_thr(bite_thr_w)
);

// File: tb/test_wdog_bark_bite.sv
module test_wdog_bark_bite;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned CNT_W  = 12;
  localparam logic [31:0] THR_MAX = 32'((1 << CNT_W) - 1);
  localparam logic [ADDR_W-1:0] A_KICK = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C,
                                A_BARK = 5'h10, A_BITE = 5'h14;
  localparam int SIG_BARK = 0, SIG_BITE = 1, SIG_FLAG = 2, SIG_RDATA = 3;

  logic clk = 1'b0, rst_por = 1'b1, rst_sys = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic bark_irq, bite_req, wdog_caused;

  int n_checks = 0, n_errs = 0;
  bit done = 1'b0;

  typedef struct { int sig; logic [31:0] exp; string req; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  wdog_bark_bite #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_wdog_bark_bite (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .bark_irq(bark_irq),
    .bite_req(bite_req), .wdog_caused(wdog_caused)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    item_t it;
    logic [31:0] obs;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.sig)
        SIG_BARK: obs = 32'(bark_irq);
        SIG_BITE: obs = 32'(bite_req);
        SIG_FLAG: obs = 32'(wdog_caused);
        default:  obs = rdata;
      endcase
      n_checks++;
      if (obs !== it.exp) begin
        n_errs++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, obs, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic expect_sig(int sig, logic [31:0] exp, string req);
    item_t it;
    it.sig = sig; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    expect_sig(SIG_RDATA, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_por = 1'b0;
    tick();
    // reset state
    expect_sig(SIG_BARK, 0, "R11 reset bark");
    expect_sig(SIG_BITE, 0, "R11 reset bite");
    expect_sig(SIG_FLAG, 0, "R10 reset flag");
    rd_check(A_CTRL, 0, "R11 ctrl default");
    rd_check(A_BITE, THR_MAX, "R11 bite default");

    // thresholds written while stopped: nothing counts (R2)
    wr(A_BARK, 5);
    wr(A_BITE, 9);
    tick(20);
    expect_sig(SIG_BITE, 0, "R2 idle bite");
    expect_sig(SIG_BARK, 0, "R2 idle bark");
    rd_check(A_BARK, 5, "R1 bark readback");
    rd_check(A_BITE, 9, "R1 bite readback");
    rd_check(A_KICK, 0, "R1 restart reads zero");

    // run with interrupt: warning at A+1, request at B+1
    wr(A_CTRL, 3);
    tick(5);  expect_sig(SIG_BARK, 0, "R4 before warning");
    tick(1);  expect_sig(SIG_BARK, 1, "R4 warning edge");
    tick(3);  expect_sig(SIG_BITE, 0, "R3 before request");
    tick(1);  expect_sig(SIG_BITE, 1, "R3 request edge");
    tick(1);  expect_sig(SIG_FLAG, 1, "R10 flag set");
    tick(50);
    expect_sig(SIG_BITE, 1, "R9 request held");
    expect_sig(SIG_BARK, 1, "R4 warning held");

    // restart: bit0=0 ignored, bit0=1 clears and restarts
    wr(A_KICK, 0);
    expect_sig(SIG_BITE, 1, "R7 restart with bit0 clear ignored");
    wr(A_KICK, 1);
    expect_sig(SIG_BITE, 0, "R7 restart clears request");
    expect_sig(SIG_BARK, 0, "R7 restart clears warning");
    tick(5);  expect_sig(SIG_BARK, 0, "R7 recount before warning");
    tick(1);  expect_sig(SIG_BARK, 1, "R7 recount warning");
    tick(3);  expect_sig(SIG_BITE, 0, "R7 recount before request");
    tick(1);  expect_sig(SIG_BITE, 1, "R7 recount request");

    // disable clears on that edge
    wr(A_CTRL, 0);
    expect_sig(SIG_BITE, 0, "R8 disable clears request");
    expect_sig(SIG_BARK, 0, "R8 disable clears warning");
    tick(30);
    expect_sig(SIG_BITE, 0, "R2 stays idle");

    // cause flag behaviour
    rd_check(A_STAT, 1, "R1 cause readback");
    wr(A_STAT, 0);
    rd_check(A_STAT, 1, "R10 write zero ignored");
    rst_sys = 1'b1; tick(); rst_sys = 1'b0; tick();
    expect_sig(SIG_FLAG, 1, "R10 survives system reset");
    rd_check(A_CTRL, 0, "R11 ctrl after system reset");
    rd_check(A_BARK, THR_MAX, "R11 bark after system reset");
    wr(A_STAT, 1);
    expect_sig(SIG_FLAG, 0, "R10 write one clears");

    // interrupt disabled: no warning, request still fires
    wr(A_BARK, 3);
    wr(A_BITE, 10);
    wr(A_CTRL, 1);
    tick(10); expect_sig(SIG_BITE, 0, "R5 before request");
    expect_sig(SIG_BARK, 0, "R5 no warning");
    tick(1);  expect_sig(SIG_BITE, 1, "R5 request fires");
    expect_sig(SIG_BARK, 0, "R5 still no warning");

    // reprogram sequence with warning above request
    wr(A_CTRL, 0);
    wr(A_KICK, 1);
    wr(A_BARK, 10);
    wr(A_BITE, 6);
    wr(A_CTRL, 3);
    tick(6);  expect_sig(SIG_BITE, 0, "R12 new limit not yet");
    tick(1);  expect_sig(SIG_BITE, 1, "R12 new limit governs");
    expect_sig(SIG_BARK, 0, "R6 warning suppressed");
    tick(20); expect_sig(SIG_BARK, 0, "R6 warning stays suppressed");

    // saturation at full counter range
    wr(A_CTRL, 0);
    rst_sys = 1'b1; tick(); rst_sys = 1'b0;
    wr(A_CTRL, 1);
    tick(4095); expect_sig(SIG_BITE, 0, "R9 before full range");
    tick(1);    expect_sig(SIG_BITE, 1, "R9 at full range");
    tick(100);  expect_sig(SIG_BITE, 1, "R9 no wrap");

    // power-on reset clears the flag
    rst_por = 1'b1; tick(); rst_por = 1'b0; tick();
    expect_sig(SIG_FLAG, 0, "R10 power-on clears flag");
    expect_sig(SIG_BITE, 0, "R11 power-on clears request");

    tick(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule